// File: doc/BRIEF.md
# Synchronous Half-Duplex Shift Port

This block moves one byte at a time over a single shared data line, either out or in, never both at once. It drives its own shift clock and runs at a fixed rate of one bit per machine cycle. A machine cycle is twelve clocks, built from six states of two phases each. Every action of the port is tied to a fixed clock within that cycle. The shift clock idles high. In each cycle of an active transfer it is low for the middle six clocks.

A host starts a transmit by pulsing a write strobe with a byte. The port drives the byte on the data line, least significant bit first, and raises a transmit-done flag. A host starts a receive by holding receive-enable high while the receive-done flag is clear. The port then clocks in eight bits, least significant bit first, presents the byte on a read port and raises the receive-done flag. The end of a byte is found by a marker bit that travels through each shift register, not by a bit counter. The host clears each flag with a strobe.

Top module: `sync_shift_port`

## Requirements
- R1: Clock positions are numbered 0 to 11 within each machine cycle, and position 0 is the first clock after reset is released. The shift clock is high whenever no transfer is active. In every machine cycle where a transfer is active, the shift clock is low at positions 4 to 9 and high at the other positions.
- R2: Suppose a write strobe is accepted in machine cycle k, at any position. Then the line is not driven in cycle k+1, and line driving (`sd_oe`=1) begins at position 0 of cycle k+2.
- R3: The transmitted byte appears on `sd_o` one bit per machine cycle, least significant bit first. Bit i is driven throughout the shift-clock-low window of cycle k+2+i.
- R4: After eight send cycles, at position 0 of cycle k+10, `sd_oe` falls and `ti` becomes 1. Both still hold their old values at position 11 of cycle k+9.
- R5: A write strobe is ignored while a transmit is pending or sending, and while a receive is active. The byte on the line is unchanged and no extra transfer follows.
- R6: If `ren` is 1, `ri` is 0 and the port is idle at position 11 of a machine cycle, then a receive starts in the next machine cycle.
- R7: During a receive, `sd_i` is sampled once per machine cycle at position 9, and the first sample becomes bit 0 of the byte. Values on `sd_i` at other positions have no effect.
- R8: After eight receive cycles, `ri` becomes 1 at position 0 of the next machine cycle, and `rd_data` holds the received byte. While `ri` is 1, no new receive starts even if `ren` stays 1.
- R9: A pulse on `clr_ti` clears `ti`, and a pulse on `clr_ri` clears `ri`. If a clear and a set land on the same clock, the flag is set.
- R10: The port drives the line (`sd_oe`=1) only while it is sending. After reset, `ti`=0, `ri`=0, `sd_oe`=0, the shift clock is 1 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | DATA_W | Byte to transmit |
| rd_data | output | DATA_W | Last byte received |
| ren | input | 1 | Receive enable |
| clr_ti | input | 1 | Clear strobe for the transmit-done flag |
| clr_ri | input | 1 | Clear strobe for the receive-done flag |
| ti | output | 1 | Transmit-done flag |
| ri | output | 1 | Receive-done flag |
| sd_o | output | 1 | Data line output value |
| sd_oe | output | 1 | Data line output enable |
| sd_i | input | 1 | Data line input value |
| sclk_o | output | 1 | Shift clock output |

## Verification
The bench tracks the machine-cycle position on its own, counting clocks from reset release, and takes every sample at a falling clock edge. For each accepted write, it expects the line to go active two cycle starts later. It expects bit i inside the low window of the following i-th cycle and expects `ti` exactly ten cycle starts after the write cycle, and it checks one position before each of these edges to confirm nothing happens early. For a receive started in cycle c, it drives bit j from position 1 to 9 of cycle c+1+j and places the opposite value around it. It then expects `ri` and the byte at position 0 of cycle c+9. Every byte value is swept, and the write and enable phases rotate through the cycle positions.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Clock position within a machine cycle for a 1-based state and phase.
  function automatic int unsigned pos_of(input int unsigned st,
                                         input int unsigned ph,
                                         input int unsigned phases);
    return (st - 1) * phases + (ph - 1);
  endfunction

  // Strobes derived from the machine-cycle position.
  typedef struct packed {
    logic cyc_end;   // last clock of the cycle: shift/update edge
    logic smp;       // line sample clock
    logic low_next;  // next position is inside the shift-clock-low window
  } ssp_ticks_t;

endpackage

// File: rtl/ssp_phase_gen.sv
module ssp_phase_gen
  import ssp_pkg::*;
#(
  parameter int unsigned NUM_STATES = 6,
  parameter int unsigned PHASES     = 2
) (
  input  logic       clk,
  input  logic       rst,
  output ssp_ticks_t ticks
);
  localparam int unsigned CYC   = NUM_STATES * PHASES;
  localparam int unsigned PH_W  = $clog2(CYC);
  localparam int unsigned LOW_A = pos_of(3, 1, PHASES);
  localparam int unsigned LOW_B = pos_of(5, PHASES, PHASES);
  localparam logic [PH_W-1:0] LAST     = PH_W'(CYC - 1);
  localparam logic [PH_W-1:0] SMP_AT   = PH_W'(LOW_B);
  localparam logic [PH_W-1:0] LOW_FROM = PH_W'(LOW_A - 1);
  localparam logic [PH_W-1:0] LOW_TO   = PH_W'(LOW_B - 1);

  logic [PH_W-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst)              pos <= '0;
    else if (pos == LAST) pos <= '0;
    else                  pos <= pos + 1'b1;
  end

  always_comb begin
    ticks.cyc_end  = (pos == LAST);
    ticks.smp      = (pos == SMP_AT);
    ticks.low_next = (pos >= LOW_FROM) && (pos <= LOW_TO);
  end

  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    (pos == LAST) |=> (pos == '0));
endmodule

// File: rtl/ssp_tx_unit.sv
module ssp_tx_unit #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_end,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rx_claim,
  output logic              tx_busy,
  output logic              send,
  output logic              sd_o,
  output logic              ti_set
);
  logic [DATA_W:0] sr;
  logic            wr_seen;
  logic            arm;
  logic            accept;
  logic            fin;

  assign tx_busy = wr_seen | arm | send;
  assign accept  = wr_en && !tx_busy && !rx_claim;
  // Marker sits just above the last data bit with zeros above it.
  assign fin     = (sr[DATA_W:2] == '0) && sr[1];
  assign ti_set  = cyc_end && send && fin;
  assign sd_o    = sr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      wr_seen <= 1'b0;
      arm     <= 1'b0;
      send    <= 1'b0;
    end else begin
      if (accept) begin
        sr <= {1'b1, wr_data};
        if (cyc_end) arm     <= 1'b1;
        else         wr_seen <= 1'b1;
      end
      if (cyc_end) begin
        if (wr_seen) begin
          wr_seen <= 1'b0;
          arm     <= 1'b1;
        end
        if (arm) begin
          arm  <= 1'b0;
          send <= 1'b1;
        end
        if (send) begin
          sr <= {1'b0, sr[DATA_W:1]};
          if (fin) send <= 1'b0;
        end
      end
    end
  end

  a_r2_start_on_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(send) |-> $past(cyc_end));
  a_r3_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (send && cyc_end) |=> (sr[DATA_W] == 1'b0));
  a_r4_marker_out: assert property (@(posedge clk) disable iff (rst)
    $fell(send) |-> (sr == {{DATA_W{1'b0}}, 1'b1}));
  a_r5_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (send && wr_en && !cyc_end) |=> $stable(sr));
endmodule

// File: rtl/ssp_rx_unit.sv
module ssp_rx_unit #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_end,
  input  logic              smp_tick,
  input  logic              ren,
  input  logic              ri,
  input  logic              tx_busy,
  input  logic              sd_i,
  output logic              recv,
  output logic              rx_claim,
  output logic [DATA_W-1:0] rd_data,
  output logic              ri_set
);
  logic [DATA_W-1:0] sr;
  logic              smp;
  logic              go;
  logic              fin;

  assign go       = cyc_end && ren && !ri && !recv && !tx_busy;
  assign rx_claim = recv | go;
  // The zero loaded at the top has walked down to bit 0.
  assign fin      = !sr[0];
  assign ri_set   = cyc_end && recv && fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      smp     <= 1'b1;
      recv    <= 1'b0;
      rd_data <= '0;
    end else begin
      if (smp_tick) smp <= sd_i;
      if (go) begin
        sr   <= {1'b0, {(DATA_W-1){1'b1}}};
        recv <= 1'b1;
      end
      if (cyc_end && recv) begin
        sr <= {smp, sr[DATA_W-1:1]};
        if (fin) begin
          recv    <= 1'b0;
          rd_data <= {smp, sr[DATA_W-1:1]};
        end
      end
    end
  end

  a_r6_start_cond: assert property (@(posedge clk) disable iff (rst)
    $rose(recv) |-> ($past(ren) && !$past(ri) && $past(cyc_end)));
  a_r7_hold_mid_cycle: assert property (@(posedge clk) disable iff (rst)
    (recv && !cyc_end) |=> $stable(sr));
  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    (ri && !recv) |=> !recv);
  a_r8_buf_hold: assert property (@(posedge clk) disable iff (rst)
    !(cyc_end && recv) |=> $stable(rd_data));
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import ssp_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned NUM_STATES = 6,
  parameter int unsigned PHASES     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ren,
  input  logic              clr_ti,
  input  logic              clr_ri,
  output logic              ti,
  output logic              ri,
  output logic              sd_o,
  output logic              sd_oe,
  input  logic              sd_i,
  output logic              sclk_o
);
  ssp_ticks_t ticks;
  logic tx_busy, send, ti_set;
  logic recv, rx_claim, ri_set;

  ssp_phase_gen #(.NUM_STATES(NUM_STATES), .PHASES(PHASES)) u_phase (
    .clk(clk), .rst(rst), .ticks(ticks)
  );

  ssp_tx_unit #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .cyc_end(ticks.cyc_end),
    .wr_en(wr_en), .wr_data(wr_data), .rx_claim(rx_claim),
    .tx_busy(tx_busy), .send(send), .sd_o(sd_o), .ti_set(ti_set)
  );

  ssp_rx_unit #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .cyc_end(ticks.cyc_end), .smp_tick(ticks.smp),
    .ren(ren), .ri(ri), .tx_busy(tx_busy), .sd_i(sd_i),
    .recv(recv), .rx_claim(rx_claim), .rd_data(rd_data), .ri_set(ri_set)
  );

  assign sd_oe = send;

  always_ff @(posedge clk) begin
    if (rst) begin
      ti     <= 1'b0;
      ri     <= 1'b0;
      sclk_o <= 1'b1;
    end else begin
      if (ti_set)      ti <= 1'b1;
      else if (clr_ti) ti <= 1'b0;
      if (ri_set)      ri <= 1'b1;
      else if (clr_ri) ri <= 1'b0;
      sclk_o <= !((send || recv) && ticks.low_next);
    end
  end

  a_r10_half_duplex: assert property (@(posedge clk) disable iff (rst)
    !(send && recv));
  a_r1_sclk_idle: assert property (@(posedge clk) disable iff (rst)
    (!send && !recv) |=> sclk_o);
  a_r9_ti_set_wins: assert property (@(posedge clk) disable iff (rst)
    ti_set |=> ti);
  a_r9_ri_set_wins: assert property (@(posedge clk) disable iff (rst)
    ri_set |=> ri);
endmodule

// File: tb/sim_sync_shift_port.sv
module sim_sync_shift_port;
  localparam int DW = 8;
  localparam int CYC = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic ren = 1'b0, clr_ti = 1'b0, clr_ri = 1'b0;
  logic ti, ri, sd_o, sd_oe, sclk_o;
  logic sd_i = 1'b1;

  int checks = 0;
  int failures = 0;
  int pos = 0;  // bench model of the machine-cycle position (R1)

  always #2 clk = ~clk;  // 250 MHz

  always @(posedge clk) pos <= rst ? 0 : ((pos == CYC - 1) ? 0 : pos + 1);

  sync_shift_port u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ren(ren), .clr_ti(clr_ti), .clr_ri(clr_ri), .ti(ti), .ri(ri),
    .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i), .sclk_o(sclk_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wait_pos(input int p);
    @(negedge clk);
    while (pos != p) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ti == 0, "R10 reset ti", ti, 0);
    chk(ri == 0, "R10 reset ri", ri, 0);
    chk(sd_oe == 0, "R10 reset oe", sd_oe, 0);
    chk(sclk_o == 1, "R10 reset sclk", sclk_o, 1);
    chk(rd_data == 0, "R10 reset rd_data", rd_data, 0);

    // Transmit sweep over all bytes, write phase rotating.
    for (int v = 0; v < 256; v++) begin
      int p;
      p = v % CYC;
      wait_pos(p);
      wr_en = 1'b1;
      wr_data = DW'(v);
      @(negedge clk);
      wr_en = 1'b0;
      if (p != CYC - 1) wait_pos(0);
      chk(sd_oe == 0, "R2 not driven in cycle k+1", sd_oe, 0);
      wait_pos(0);
      chk(sd_oe == 1, "R2 driven from cycle k+2", sd_oe, 1);
      for (int i = 0; i < DW; i++) begin
        wait_pos(1);
        chk(sclk_o == 1, "R1 sclk high at pos 1", sclk_o, 1);
        wait_pos(6);
        chk(sclk_o == 0, "R1 sclk low at pos 6", sclk_o, 0);
        chk(sd_o == v[i], "R3 bit value", sd_o, v[i]);
        chk(sd_oe == 1, "R10 oe while sending", sd_oe, 1);
        if (i == 2) begin
          wr_en = 1'b1;
          wr_data = ~DW'(v);
          @(negedge clk);
          wr_en = 1'b0;
        end
        if (i == DW - 1) begin
          wait_pos(CYC - 1);
          chk(ti == 0 && sd_oe == 1, "R4 not early at pos 11", {ti, sd_oe}, 2'b01);
          if (v % 4 == 0) clr_ti = 1'b1;  // R9 clear colliding with set
        end
        wait_pos(0);
      end
      chk(ti == 1, "R4 ti set / R9 set wins", ti, 1);
      chk(sd_oe == 0, "R4 oe released", sd_oe, 0);
      clr_ti = 1'b1;
      @(negedge clk);
      clr_ti = 1'b0;
      chk(ti == 0, "R9 clr_ti clears", ti, 0);
      wait_pos(6);
      chk(sd_oe == 0 && sclk_o == 1, "R5 no extra transfer", {sd_oe, sclk_o}, 2'b01);
    end

    // Receive sweep over all bytes, enable phase rotating.
    for (int v = 0; v < 256; v++) begin
      int p;
      p = v % (CYC - 1);
      wait_pos(p);
      ren = 1'b1;
      wait_pos(0);
      for (int j = 0; j < DW; j++) begin
        wait_pos(1);
        sd_i = v[j];
        wait_pos(6);
        chk(sclk_o == 0, "R6 receive running, sclk low", sclk_o, 0);
        chk(sd_oe == 0, "R10 line released in receive", sd_oe, 0);
        if (j == 3) begin
          wr_en = 1'b1;
          wr_data = 8'h00;
          @(negedge clk);
          wr_en = 1'b0;
        end
        wait_pos(10);
        sd_i = ~v[j];
      end
      wait_pos(CYC - 1);
      chk(ri == 0, "R8 ri not early", ri, 0);
      wait_pos(0);
      chk(ri == 1, "R8 ri set", ri, 1);
      chk(rd_data == DW'(v), "R7 received byte", rd_data, v);
      chk(sd_oe == 0, "R5 write during receive ignored", sd_oe, 0);
      wait_pos(6);
      chk(sclk_o == 1, "R8 no restart while ri", sclk_o, 1);
      chk(sd_oe == 0, "R5 no transmit after receive", sd_oe, 0);
      clr_ri = 1'b1;
      ren = 1'b0;
      @(negedge clk);
      clr_ri = 1'b0;
      chk(ri == 0, "R9 clr_ri clears", ri, 0);
      sd_i = 1'b1;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule